// File: doc/BRIEF.md
# Two-Bank Shared Buffer Arbiter

This block places a buffer RAM, split into two equal banks, between an external host port and an internal CPU port. Each port has a request, a write enable, a word address, write data, read data and a ready signal. Two configuration bits, a split-mode bit and a bank bit, decide which port reaches which bank. When split mode is off, both ports use the one bank named by the bank bit, and a fixed priority settles any collision. When split mode is on, each port is tied to its own bank and both run at full rate in parallel.

A requester raises its request with address and data, and keeps them steady until it sees ready high in that cycle. Ready is combinational. An access counts as granted in the cycle where request and ready are both high. Read data comes back on the next clock. Neither port carries a bank address bit: the port address picks a word inside whichever bank the current setting gives that port. Configuration inputs are sampled only when the block is idle, so a change never splits a transaction.

Top module: `dbank_arb`

## Requirements
- R1: After reset the applied setting is split=0, bank=0 (both ports share bank 0), both read data outputs are 0, and an idle port shows ready low.
- R2: With split=0, bank=0, both ports read and write bank 0: a word written through one port reads back through the other at the same address, and bank 1 is never touched.
- R3: With split=0, bank=1, both ports read and write bank 1 only. Bank 0 contents are neither visible nor changed.
- R4: With split=0, if both ports request in the same cycle and no CPU access is waiting, the host gets ready high and the CPU gets ready low, whatever the addresses. In the next cycle the waiting CPU access is granted, and a host request in that cycle sees ready low.
- R5: With split=1, bank=0, the host port reaches only bank 0 and the CPU port reaches only bank 1.
- R6: With split=1, bank=1, the host port reaches only bank 1 and the CPU port reaches only bank 0.
- R7: With split=1, each port's ready equals its own request in every cycle, so simultaneous accesses from both ports complete in the same cycle.
- R8: A granted read returns the addressed word on the port's read data output one clock later. That value holds through idle cycles and writes until the port's next granted read.
- R9: The configuration inputs take effect only at a clock edge where neither port is requesting and no CPU access is waiting. While any access is active, the applied setting stays unchanged.
- R10: The address selects a word within the granted bank, so the same address in bank 0 and bank 1 holds independent data, across the full range from 0 to the top address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_split | input | 1 | Requested mode: 1 gives each port its own bank |
| cfg_bank | input | 1 | Requested bank bit (shared bank, or host bank in split mode) |
| h_req | input | 1 | Host access request |
| h_we | input | 1 | Host write enable |
| h_addr | input | ADDR_W | Host word address within its bank |
| h_wdata | input | DATA_W | Host write data |
| h_rdata | output | DATA_W | Host read data |
| h_ready | output | 1 | Host access granted this cycle |
| c_req | input | 1 | CPU access request |
| c_we | input | 1 | CPU write enable |
| c_addr | input | ADDR_W | CPU word address within its bank |
| c_wdata | input | DATA_W | CPU write data |
| c_rdata | output | DATA_W | CPU read data |
| c_ready | output | 1 | CPU access granted this cycle |

## Verification
The bench builds the block with its default parameters: 16-bit data and 8-bit addresses, which gives two banks of 256 words. With these values the top address 0xFF can be reached directly, so the bench checks the upper edge of the bank with its own distinct data. Distinct patterns at address 0x10 in each bank make every one of the four settings tell apart which bank a port actually reached. The short bank depth also keeps the bench able to show that setting 01 leaves bank 0 untouched, with no need to sweep a large array.

// File: rtl/dbank_pkg.sv
package dbank_pkg;

    localparam int NBANK = 2;

    typedef logic bank_id_t;

    typedef struct packed {
        logic split;
        logic bank;
        logic c_wait;
    } dbank_state_t;

endpackage

// File: rtl/dbank_ram.sv
module dbank_ram #(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] dout
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];
    logic [DATA_W-1:0] dout_q;

    always_ff @(posedge clk) begin
        if (en && we) begin
            mem[addr] <= wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dout_q <= '0;
        end else if (en && !we) begin
            dout_q <= mem[addr];
        end
    end

    assign dout = dout_q;
endmodule

// File: rtl/dbank_route.sv
module dbank_route
    import dbank_pkg::*;
(
    input  dbank_state_t st,
    input  logic         h_req,
    input  logic         c_req,
    output logic         h_gnt,
    output logic         c_gnt,
    output bank_id_t     h_bank,
    output bank_id_t     c_bank,
    output logic         c_wait_next
);
    always_comb begin
        h_bank = st.bank;
        c_bank = st.split ? ~st.bank : st.bank;
        if (st.split) begin
            h_gnt       = h_req;
            c_gnt       = c_req;
            c_wait_next = 1'b0;
        end else if (st.c_wait) begin
            // CPU lost last cycle: it owns the shared bank now
            h_gnt       = 1'b0;
            c_gnt       = c_req;
            c_wait_next = 1'b0;
        end else begin
            h_gnt       = h_req;
            c_gnt       = c_req && !h_req;
            c_wait_next = c_req && h_req;
        end
    end
endmodule

// File: rtl/dbank_rport.sv
module dbank_rport
    import dbank_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         rd_gnt,
    input  bank_id_t                     bank,
    input  logic [NBANK-1:0][DATA_W-1:0] bank_dout,
    output logic [DATA_W-1:0]            rdata
);
    logic              vld_d, vld_q;
    bank_id_t          bank_d, bank_q;
    logic [DATA_W-1:0] hold_d, hold_q;

    always_comb begin
        vld_d  = rd_gnt;
        bank_d = rd_gnt ? bank : bank_q;
        rdata  = vld_q ? bank_dout[bank_q] : hold_q;
        hold_d = rdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld_q  <= 1'b0;
            bank_q <= 1'b0;
            hold_q <= '0;
        end else begin
            vld_q  <= vld_d;
            bank_q <= bank_d;
            hold_q <= hold_d;
        end
    end
endmodule

// File: rtl/dbank_arb.sv
module dbank_arb
    import dbank_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_split,
    input  logic              cfg_bank,
    input  logic              h_req,
    input  logic              h_we,
    input  logic [ADDR_W-1:0] h_addr,
    input  logic [DATA_W-1:0] h_wdata,
    output logic [DATA_W-1:0] h_rdata,
    output logic              h_ready,
    input  logic              c_req,
    input  logic              c_we,
    input  logic [ADDR_W-1:0] c_addr,
    input  logic [DATA_W-1:0] c_wdata,
    output logic [DATA_W-1:0] c_rdata,
    output logic              c_ready
);
    dbank_state_t st_d, st_q;

    logic     h_gnt, c_gnt, c_wait_next;
    bank_id_t h_bank, c_bank;

    logic [NBANK-1:0][DATA_W-1:0] bank_dout;
    logic [NBANK-1:0]             ram_en, ram_we;
    logic [NBANK-1:0][ADDR_W-1:0] ram_addr;
    logic [NBANK-1:0][DATA_W-1:0] ram_wdata;

    dbank_route u_route (
        .st          (st_q),
        .h_req       (h_req),
        .c_req       (c_req),
        .h_gnt       (h_gnt),
        .c_gnt       (c_gnt),
        .h_bank      (h_bank),
        .c_bank      (c_bank),
        .c_wait_next (c_wait_next)
    );

    always_comb begin
        st_d        = st_q;
        st_d.c_wait = c_wait_next;
        if (!h_req && !c_req && !st_q.c_wait) begin
            st_d.split = cfg_split;
            st_d.bank  = cfg_bank;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign h_ready = h_gnt;
    assign c_ready = c_gnt;

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        logic use_h, use_c;
        always_comb begin
            use_h        = h_gnt && (h_bank == bank_id_t'(b));
            use_c        = c_gnt && (c_bank == bank_id_t'(b));
            ram_en[b]    = use_h || use_c;
            ram_we[b]    = use_h ? h_we    : c_we;
            ram_addr[b]  = use_h ? h_addr  : c_addr;
            ram_wdata[b] = use_h ? h_wdata : c_wdata;
        end

        dbank_ram #(
            .DATA_W (DATA_W),
            .ADDR_W (ADDR_W)
        ) u_ram (
            .clk   (clk),
            .rst_n (rst_n),
            .en    (ram_en[b]),
            .we    (ram_we[b]),
            .addr  (ram_addr[b]),
            .wdata (ram_wdata[b]),
            .dout  (bank_dout[b])
        );
    end

    dbank_rport #(.DATA_W(DATA_W)) u_hport (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_gnt    (h_gnt && !h_we),
        .bank      (h_bank),
        .bank_dout (bank_dout),
        .rdata     (h_rdata)
    );

    dbank_rport #(.DATA_W(DATA_W)) u_cport (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_gnt    (c_gnt && !c_we),
        .bank      (c_bank),
        .bank_dout (bank_dout),
        .rdata     (c_rdata)
    );
endmodule

// File: rtl/dbank_arb_chk.sv
module dbank_arb_chk #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              split_q,
    input logic              bank_q,
    input logic              c_wait_q,
    input logic              h_req,
    input logic              h_we,
    input logic              h_ready,
    input logic [DATA_W-1:0] h_rdata,
    input logic              c_req,
    input logic              c_we,
    input logic              c_ready,
    input logic [DATA_W-1:0] c_rdata
);
    p_host_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!split_q && h_req && c_req && !c_wait_q) |-> (h_ready && !c_ready));

    p_cpu_next_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!split_q && c_req && !c_ready) |=> (c_ready || !c_req));

    p_one_grant_shared_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !split_q |-> !(h_ready && c_ready));

    p_split_nostall_r7: assert property (@(posedge clk) disable iff (!rst_n)
        split_q |-> ((h_ready == h_req) && (c_ready == c_req)));

    p_cfg_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (h_req || c_req || c_wait_q) |=> $stable({split_q, bank_q}));

    p_h_rdata_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(h_ready && !h_we) |=> $stable(h_rdata));

    p_c_rdata_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(c_ready && !c_we) |=> $stable(c_rdata));

    p_ready_needs_req_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (h_ready -> h_req) && (c_ready -> c_req));
endmodule

bind dbank_arb dbank_arb_chk #(.DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .split_q  (st_q.split),
    .bank_q   (st_q.bank),
    .c_wait_q (st_q.c_wait),
    .h_req    (h_req),
    .h_we     (h_we),
    .h_ready  (h_ready),
    .h_rdata  (h_rdata),
    .c_req    (c_req),
    .c_we     (c_we),
    .c_ready  (c_ready),
    .c_rdata  (c_rdata)
);

// File: tb/dbank_arb_tb_top.sv
`timescale 1ns/1ps
module dbank_arb_tb_top;
    localparam int DATA_W = 16;
    localparam int ADDR_W = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_split = 1'b0, cfg_bank = 1'b0;
    logic              h_req = 1'b0, h_we = 1'b0, c_req = 1'b0, c_we = 1'b0;
    logic [ADDR_W-1:0] h_addr = '0, c_addr = '0;
    logic [DATA_W-1:0] h_wdata = '0, c_wdata = '0;
    logic [DATA_W-1:0] h_rdata, c_rdata;
    logic              h_ready, c_ready;

    int n_chk = 0;
    int n_err = 0;

    always #2.5 clk = ~clk;

    dbank_arb #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_split(cfg_split), .cfg_bank(cfg_bank),
        .h_req(h_req), .h_we(h_we), .h_addr(h_addr), .h_wdata(h_wdata),
        .h_rdata(h_rdata), .h_ready(h_ready),
        .c_req(c_req), .c_we(c_we), .c_addr(c_addr), .c_wdata(c_wdata),
        .c_rdata(c_rdata), .c_ready(c_ready)
    );

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic idle();
        h_req = 1'b0; c_req = 1'b0; h_we = 1'b0; c_we = 1'b0;
    endtask

    task automatic set_cfg(input logic s, input logic b);
        @(negedge clk);
        idle();
        cfg_split = s; cfg_bank = b;
        @(negedge clk);
    endtask

    // single solo access by one port, ready expected high
    task automatic acc(input bit cpu, input logic we, input logic [ADDR_W-1:0] a,
                       input logic [DATA_W-1:0] d, input string tag);
        @(negedge clk);
        idle();
        if (cpu) begin c_req = 1'b1; c_we = we; c_addr = a; c_wdata = d; end
        else     begin h_req = 1'b1; h_we = we; h_addr = a; h_wdata = d; end
        #1;
        chk(cpu ? c_ready : h_ready, 1'b1, tag);
        @(negedge clk);
        idle();
    endtask

    task automatic rd_chk(input bit cpu, input logic [ADDR_W-1:0] a,
                          input logic [DATA_W-1:0] exp, input string tag);
        acc(cpu, 1'b0, a, '0, tag);
        #1;
        chk(cpu ? c_rdata : h_rdata, exp, tag);
    endtask

    task automatic t_reset();
        #1;
        chk(h_ready, 0, "R1 host ready idle");
        chk(c_ready, 0, "R1 cpu ready idle");
        chk(h_rdata, 0, "R1 host rdata");
        chk(c_rdata, 0, "R1 cpu rdata");
    endtask

    task automatic t_shared_bank0();
        set_cfg(0, 0);
        acc(0, 1, 8'h10, 16'h1111, "R2 host write bank0");
        acc(1, 1, 8'hFF, 16'h1FF1, "R10 cpu write bank0 top");
        rd_chk(1, 8'h10, 16'h1111, "R2 cpu reads host word");
        rd_chk(0, 8'hFF, 16'h1FF1, "R2 host reads cpu word");
    endtask

    task automatic t_shared_bank1();
        set_cfg(0, 1);
        acc(1, 1, 8'h10, 16'h2222, "R3 cpu write bank1");
        acc(0, 1, 8'hFF, 16'h2FF2, "R10 host write bank1 top");
        rd_chk(0, 8'h10, 16'h2222, "R3 host reads bank1");
        rd_chk(1, 8'hFF, 16'h2FF2, "R10 cpu reads bank1 top");
        set_cfg(0, 0);
        rd_chk(0, 8'h10, 16'h1111, "R3 bank0 untouched");
        rd_chk(1, 8'hFF, 16'h1FF1, "R10 bank0 top independent");
    endtask

    task automatic t_collision();
        set_cfg(0, 0);
        acc(0, 1, 8'h05, 16'h0505, "R4 prep");
        acc(0, 1, 8'h06, 16'h0606, "R4 prep");
        acc(0, 1, 8'h07, 16'h0707, "R4 prep");
        @(negedge clk);
        h_req = 1; h_we = 0; h_addr = 8'h05;
        c_req = 1; c_we = 0; c_addr = 8'h06;
        #1;
        chk(h_ready, 1, "R4 host wins");
        chk(c_ready, 0, "R4 cpu stalled");
        @(negedge clk);
        h_addr = 8'h07;
        #1;
        chk(h_ready, 0, "R4 host yields next cycle");
        chk(c_ready, 1, "R4 cpu served next cycle");
        chk(h_rdata, 16'h0505, "R8 host read one clock later");
        @(negedge clk);
        c_req = 0;
        #1;
        chk(c_rdata, 16'h0606, "R4 cpu data");
        chk(h_ready, 1, "R4 host resumes");
        @(negedge clk);
        idle();
        #1;
        chk(h_rdata, 16'h0707, "R4 host second read");
    endtask

    task automatic t_split(input logic b);
        set_cfg(1, b);
        @(negedge clk);
        h_req = 1; h_we = 0; h_addr = 8'h10;
        c_req = 1; c_we = 0; c_addr = 8'h10;
        #1;
        chk(h_ready, 1, "R7 host ready split");
        chk(c_ready, 1, "R7 cpu ready split");
        @(negedge clk);
        idle();
        #1;
        chk(h_rdata, b ? 16'h2222 : 16'h1111, b ? "R6 host bank1" : "R5 host bank0");
        chk(c_rdata, b ? 16'h1111 : 16'h2222, b ? "R6 cpu bank0" : "R5 cpu bank1");
    endtask

    task automatic t_split_writes();
        set_cfg(1, 0);
        @(negedge clk);
        h_req = 1; h_we = 1; h_addr = 8'h20; h_wdata = 16'hA0A0;
        c_req = 1; c_we = 1; c_addr = 8'h20; c_wdata = 16'hB0B0;
        #1;
        chk({h_ready, c_ready}, 2'b11, "R7 parallel writes");
        @(negedge clk);
        idle();
        set_cfg(0, 1);
        rd_chk(1, 8'h20, 16'hB0B0, "R5 cpu write went to bank1");
        set_cfg(0, 0);
        rd_chk(1, 8'h20, 16'hA0A0, "R5 host write went to bank0");
    endtask

    task automatic t_hold();
        set_cfg(0, 0);
        rd_chk(1, 8'h10, 16'h1111, "R8 read");
        repeat (3) @(negedge clk);
        #1;
        chk(c_rdata, 16'h1111, "R8 hold over idle");
        acc(1, 1, 8'h30, 16'h3333, "R8 write");
        #1;
        chk(c_rdata, 16'h1111, "R8 hold over write");
        acc(0, 0, 8'h30, '0, "R8 other port read");
        #1;
        chk(c_rdata, 16'h1111, "R8 hold over other port read");
    endtask

    task automatic t_cfg_gate();
        set_cfg(0, 0);
        @(negedge clk);
        cfg_split = 0; cfg_bank = 1;
        c_req = 1; c_we = 0; c_addr = 8'h10;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            #1;
            chk(c_rdata, 16'h1111, "R9 setting frozen while busy");
        end
        idle();
        @(negedge clk);
        rd_chk(1, 8'h10, 16'h2222, "R9 setting applied when idle");
    endtask

    initial begin
        #20000;
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_shared_bank0();
        t_shared_bank1();
        t_collision();
        t_split(1'b0);
        t_split(1'b1);
        t_split_writes();
        t_hold();
        t_cfg_gate();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule